// File: doc/BRIEF.md
# Per-Pin Configurable Interrupt Detector

This block watches a group of input pins (32 by default) and raises a single interrupt request when any pin shows the condition it was configured for. Each pin owns a control word on a simple register bus. A 4-bit detection code inside that word selects what counts as an event: nothing, a low level, a high level, a rising edge, a falling edge or either edge. The pins are first synchronised to the clock, and edges are found by comparing the synchronised value with a copy one cycle older.

Each event sets a sticky bit in a status-flag word. Software reads that word to find the pins that fired and writes ones to clear them. A level condition that is still present sets its flag again straight away, so software cannot clear it until the pin leaves that level. The interrupt request is the registered OR of all flags.

Top module: `pin_irq_unit`

## Requirements
- R1: After a synchronous reset every detection code is 0, every flag is 0, `irq_req` is 0 and `bus_rdata` is 0.
- R2: The control word of pin n sits at byte address 4·n. A write stores bits 19:16 of the data as that pin's detection code. A read returns the code in bits 19:16 and zeros in every other bit. Writing 0 masks the pin, so later pin activity sets no flag.
- R3: Code 0x8 sets the pin's flag whenever the synchronised pin is 0.
- R4: Code 0xC sets the pin's flag whenever the synchronised pin is 1. A clear written while the pin stays high leaves the flag set.
- R5: Code 0x9 sets the flag on a 0-to-1 transition and not on a steady level.
- R6: Code 0xA sets the flag on a 1-to-0 transition and not on a steady level.
- R7: Code 0xB sets the flag on a transition in either direction and not on a steady level.
- R8: Code 0x0 and every code not listed in R3 to R7 set no flag.
- R9: The flag word is at address 0xA0, with bit n for pin n. Writing it clears every flag whose data bit is 1 and leaves flags whose data bit is 0 unchanged. Writing all ones clears all flags.
- R10: When an event and a clear of the same flag happen in the same cycle, the flag ends up set.
- R11: `irq_req` is the OR of all flags, registered. A pin change driven before clock edge E1 sets its flag at edge E3 and raises `irq_req` at edge E4.
- R12: A read returns its data on `bus_rdata` after the next clock edge. Addresses that are neither a control word nor the flag word read as 0. `bus_rdata` holds its value between reads.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| bus_en | input | 1 | Bus access strobe, one cycle per access |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | ADDR_W | Byte address |
| bus_wdata | input | DATA_W | Write data |
| bus_rdata | output | DATA_W | Registered read data |
| pins_in | input | N_PINS | Asynchronous pin inputs |
| irq_req | output | 1 | Combined interrupt request, registered |

## Verification
A wrong stored detection code shows up within one read of that pin's control word. It also shows up as a missing or extra flag about three cycles after the pin moves. A flag register that clears the wrong bits, or that lets a clear override a same-cycle event, shows up as a wrong flag word on the next read. A stale `irq_req` shows up one cycle after the flags change. The bench drives each code against matched pairs of pin histories, one that must fire and one that must not. It samples `irq_req` on the exact edge where the request must rise, and it times a clear to land on the same edge as an event.

// File: rtl/pin_irq_pkg.sv
package pin_irq_pkg;
  localparam int CODE_W    = 4;
  localparam int FIELD_LSB = 16;

  typedef enum logic [CODE_W-1:0] {
    DET_OFF  = 4'h0,
    DET_LOW  = 4'h8,
    DET_RISE = 4'h9,
    DET_FALL = 4'hA,
    DET_BOTH = 4'hB,
    DET_HIGH = 4'hC
  } det_code_e;

  typedef struct packed {
    logic lvl_lo;
    logic lvl_hi;
    logic rise;
    logic fall;
  } det_sel_t;

  // Unlisted codes decode to no detection at all.
  function automatic det_sel_t decode_code(input logic [CODE_W-1:0] c);
    det_sel_t s;
    s = '0;
    case (c)
      DET_LOW:  s.lvl_lo = 1'b1;
      DET_HIGH: s.lvl_hi = 1'b1;
      DET_RISE: s.rise   = 1'b1;
      DET_FALL: s.fall   = 1'b1;
      DET_BOTH: begin
        s.rise = 1'b1;
        s.fall = 1'b1;
      end
      default:  s = '0;
    endcase
    return s;
  endfunction
endpackage

// File: rtl/pin_sync.sv
module pin_sync #(
  parameter int WIDTH  = 32,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] raw,
  output logic [WIDTH-1:0] cur,
  output logic [WIDTH-1:0] prev
);
  // STAGES flops form the synchroniser; one extra flop holds the older copy.
  logic [STAGES:0][WIDTH-1:0] stg;

  always_ff @(posedge clk) begin
    if (rst) begin
      stg <= '0;
    end else begin
      stg[0] <= raw;
      for (int s = 1; s <= STAGES; s++) stg[s] <= stg[s-1];
    end
  end

  assign cur  = stg[STAGES-1];
  assign prev = stg[STAGES];
endmodule

// File: rtl/pin_cfg_bank.sv
module pin_cfg_bank
  import pin_irq_pkg::*;
#(
  parameter int N_PINS = 32,
  parameter int IDX_W  = $clog2(N_PINS)
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     wr_en,
  input  logic [IDX_W-1:0]         wr_idx,
  input  logic [CODE_W-1:0]        wr_code,
  input  logic [IDX_W-1:0]         rd_idx,
  output logic [CODE_W-1:0]        rd_code,
  output logic [N_PINS*CODE_W-1:0] codes
);
  logic [CODE_W-1:0] code_q [N_PINS];

  for (genvar i = 0; i < N_PINS; i++) begin : g_pin
    always_ff @(posedge clk) begin
      if (rst)
        code_q[i] <= DET_OFF;
      else if (wr_en && (wr_idx == IDX_W'(i)))
        code_q[i] <= wr_code;
    end
    assign codes[i*CODE_W +: CODE_W] = code_q[i];
  end

  assign rd_code = code_q[rd_idx];
endmodule

// File: rtl/pin_event_gen.sv
module pin_event_gen
  import pin_irq_pkg::*;
#(
  parameter int N_PINS = 32
) (
  input  logic [N_PINS*CODE_W-1:0] codes,
  input  logic [N_PINS-1:0]        cur,
  input  logic [N_PINS-1:0]        prev,
  output logic [N_PINS-1:0]        evt
);
  for (genvar i = 0; i < N_PINS; i++) begin : g_det
    det_sel_t sel;
    assign sel    = decode_code(codes[i*CODE_W +: CODE_W]);
    assign evt[i] = (sel.lvl_lo & ~cur[i])
                  | (sel.lvl_hi &  cur[i])
                  | (sel.rise   &  cur[i] & ~prev[i])
                  | (sel.fall   & ~cur[i] &  prev[i]);
  end
endmodule

// File: rtl/flag_bank.sv
module flag_bank #(
  parameter int N_PINS = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [N_PINS-1:0] set_vec,
  input  logic [N_PINS-1:0] clr_vec,
  output logic [N_PINS-1:0] flags,
  output logic              irq
);
  logic [N_PINS-1:0] flag_q;
  logic              irq_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      flag_q <= '0;
      irq_q  <= 1'b0;
    end else begin
      flag_q <= (flag_q & ~clr_vec) | set_vec;  // set has priority
      irq_q  <= |flag_q;
    end
  end

  assign flags = flag_q;
  assign irq   = irq_q;
endmodule

// File: rtl/pin_irq_unit.sv
module pin_irq_unit
  import pin_irq_pkg::*;
#(
  parameter int                N_PINS    = 32,
  parameter int                ADDR_W    = 8,
  parameter int                DATA_W    = 32,
  parameter int                SYNC_STG  = 2,
  parameter logic [ADDR_W-1:0] FLAG_ADDR = 8'hA0
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bus_en,
  input  logic              bus_we,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  input  logic [N_PINS-1:0] pins_in,
  output logic              irq_req
);
  localparam int IDX_W  = $clog2(N_PINS);
  localparam int WIDX_W = ADDR_W - 2;

  logic [WIDX_W-1:0]        widx;
  logic                     cfg_hit, flag_hit;
  logic                     cfg_wr, flag_wr, rd_acc;
  logic [IDX_W-1:0]         cfg_idx;
  logic [CODE_W-1:0]        rd_code;
  logic [N_PINS*CODE_W-1:0] cfg_codes;
  logic [N_PINS-1:0]        pin_cur, pin_prev, pin_evt, clr_vec, flag_q;
  logic [DATA_W-1:0]        rd_word, rdata_q;

  assign widx     = bus_addr[ADDR_W-1:2];
  assign cfg_hit  = (bus_addr[1:0] == 2'b00) && (int'(widx) < N_PINS);
  assign flag_hit = (bus_addr == FLAG_ADDR);
  assign cfg_idx  = widx[IDX_W-1:0];
  assign cfg_wr   = bus_en && bus_we && cfg_hit;
  assign flag_wr  = bus_en && bus_we && flag_hit;
  assign rd_acc   = bus_en && !bus_we;
  assign clr_vec  = flag_wr ? bus_wdata[N_PINS-1:0] : '0;

  pin_sync #(.WIDTH(N_PINS), .STAGES(SYNC_STG)) u_sync (
    .clk(clk), .rst(rst), .raw(pins_in), .cur(pin_cur), .prev(pin_prev)
  );

  pin_cfg_bank #(.N_PINS(N_PINS), .IDX_W(IDX_W)) u_cfg (
    .clk(clk), .rst(rst),
    .wr_en(cfg_wr), .wr_idx(cfg_idx),
    .wr_code(bus_wdata[FIELD_LSB +: CODE_W]),
    .rd_idx(cfg_idx), .rd_code(rd_code), .codes(cfg_codes)
  );

  pin_event_gen #(.N_PINS(N_PINS)) u_evt (
    .codes(cfg_codes), .cur(pin_cur), .prev(pin_prev), .evt(pin_evt)
  );

  flag_bank #(.N_PINS(N_PINS)) u_flag (
    .clk(clk), .rst(rst), .set_vec(pin_evt), .clr_vec(clr_vec),
    .flags(flag_q), .irq(irq_req)
  );

  always_comb begin
    rd_word = '0;
    if (cfg_hit)
      rd_word[FIELD_LSB +: CODE_W] = rd_code;
    else if (flag_hit)
      rd_word[N_PINS-1:0] = flag_q;
  end

  always_ff @(posedge clk) begin
    if (rst)
      rdata_q <= '0;
    else if (rd_acc)
      rdata_q <= rd_word;
  end

  assign bus_rdata = rdata_q;
endmodule

// File: rtl/pin_irq_chk.sv
module pin_irq_chk
  import pin_irq_pkg::*;
#(
  parameter int                N_PINS    = 32,
  parameter int                ADDR_W    = 8,
  parameter int                DATA_W    = 32,
  parameter logic [ADDR_W-1:0] FLAG_ADDR = 8'hA0
) (
  input logic                     clk,
  input logic                     rst,
  input logic                     bus_en,
  input logic                     bus_we,
  input logic [ADDR_W-1:0]        bus_addr,
  input logic [DATA_W-1:0]        bus_wdata,
  input logic [DATA_W-1:0]        bus_rdata,
  input logic [N_PINS*CODE_W-1:0] cfg_codes,
  input logic [N_PINS-1:0]        flag_q,
  input logic                     irq_req
);
  function automatic logic code_live(input logic [CODE_W-1:0] c);
    det_sel_t s;
    s = decode_code(c);
    return |s;
  endfunction

  p_irq_or_r11: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) |-> (irq_req == $past(|flag_q)));

  p_rdata_hold_r12: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && !$past(bus_en && !bus_we)) |-> $stable(bus_rdata));

  for (genvar i = 0; i < N_PINS; i++) begin : g_pin
    localparam logic [ADDR_W-1:0] CFG_A = ADDR_W'(i*4);

    p_cfg_store_r2: assert property (@(posedge clk) disable iff (rst)
      (!$past(rst) && $past(bus_en && bus_we && bus_addr == CFG_A))
      |-> (cfg_codes[i*CODE_W +: CODE_W] == $past(bus_wdata[FIELD_LSB +: CODE_W])));

    p_no_flag_when_off_r8: assert property (@(posedge clk) disable iff (rst)
      $rose(flag_q[i]) |-> code_live($past(cfg_codes[i*CODE_W +: CODE_W])));

    p_clear_needs_one_r9: assert property (@(posedge clk) disable iff (rst)
      $fell(flag_q[i]) |-> $past(bus_en && bus_we && bus_addr == FLAG_ADDR && bus_wdata[i]));
  end
endmodule

bind pin_irq_unit pin_irq_chk #(
  .N_PINS(N_PINS), .ADDR_W(ADDR_W), .DATA_W(DATA_W), .FLAG_ADDR(FLAG_ADDR)
) u_chk (
  .clk(clk), .rst(rst), .bus_en(bus_en), .bus_we(bus_we),
  .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
  .cfg_codes(cfg_codes), .flag_q(flag_q), .irq_req(irq_req)
);

// File: tb/sim_pin_irq_unit.sv
`timescale 1ns/1ps
module sim_pin_irq_unit;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        bus_en = 1'b0, bus_we = 1'b0;
  logic [7:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic [31:0] pins = '0;
  logic        irq_req;
  int          total = 0, bad = 0;

  always #10 clk = ~clk;

  pin_irq_unit u0 (
    .clk(clk), .rst(rst), .bus_en(bus_en), .bus_we(bus_we),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .pins_in(pins), .irq_req(irq_req)
  );

  localparam logic [7:0] FLAGS = 8'hA0;
  localparam int NV = 14;
  // {code, level before the code is set, level after, expected flag}
  localparam logic [6:0] VECS [NV] = '{
    {4'h8, 1'b1, 1'b0, 1'b1}, {4'h8, 1'b1, 1'b1, 1'b0},
    {4'hC, 1'b0, 1'b1, 1'b1}, {4'hC, 1'b0, 1'b0, 1'b0},
    {4'h9, 1'b0, 1'b1, 1'b1}, {4'h9, 1'b1, 1'b0, 1'b0},
    {4'hA, 1'b1, 1'b0, 1'b1}, {4'hA, 1'b0, 1'b1, 1'b0},
    {4'hB, 1'b0, 1'b1, 1'b1}, {4'hB, 1'b1, 1'b0, 1'b1},
    {4'hB, 1'b1, 1'b1, 1'b0}, {4'h0, 1'b0, 1'b1, 1'b0},
    {4'h5, 1'b0, 1'b1, 1'b0}, {4'hD, 1'b1, 1'b0, 1'b0}
  };

  task automatic check(input string req, input logic [31:0] got, input logic [31:0] exp);
    total++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, got, exp);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) begin
      @(posedge clk);
      #1;
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    bus_en = 1'b1; bus_we = 1'b1; bus_addr = a; bus_wdata = d;
    tick(1);
    bus_en = 1'b0; bus_we = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    bus_en = 1'b1; bus_we = 1'b0; bus_addr = a;
    tick(1);
    bus_en = 1'b0;
    d = bus_rdata;
  endtask

  function automatic string tag_of(input logic [3:0] c);
    case (c)
      4'h8: return "R3";
      4'hC: return "R4";
      4'h9: return "R5";
      4'hA: return "R6";
      4'hB: return "R7";
      default: return "R8";
    endcase
  endfunction

  initial begin
    repeat (100000) @(posedge clk);
    bad++; total++;
    $display("FAIL R12 watchdog actual=hung expected=finished");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [31:0] d, held;
    tick(3);
    rst = 1'b0;
    tick(1);

    // R1 reset state
    check("R1 irq", {31'b0, irq_req}, 32'h0);
    check("R1 rdata", bus_rdata, 32'h0);
    rd(FLAGS, d); check("R1 flags", d, 32'h0);
    rd(8'h14, d); check("R1 cfg pin5", d, 32'h0);

    // R2 readback, R12 unmapped and hold
    wr(8'd28, 32'hFFF9_FFFF);
    rd(8'd28, d); check("R2 field readback", d, 32'h0009_0000);
    held = d;
    tick(3); check("R12 hold", bus_rdata, held);
    rd(8'h90, d); check("R12 unmapped", d, 32'h0);
    rd(8'h1D, d); check("R12 misaligned", d, 32'h0);
    wr(8'd28, 32'h0);

    // Table walk on pin 0: R3..R8
    for (int k = 0; k < NV; k++) begin
      wr(8'h00, 32'h0);
      pins[0] = VECS[k][2];
      tick(6);
      wr(FLAGS, 32'hFFFF_FFFF);
      wr(8'h00, {12'h0, VECS[k][6:3], 16'h0});
      pins[0] = VECS[k][1];
      tick(6);
      rd(FLAGS, d);
      check(tag_of(VECS[k][6:3]), {31'b0, d[0]}, {31'b0, VECS[k][0]});
    end
    wr(8'h00, 32'h0);
    pins[0] = 1'b0;
    tick(6);
    wr(FLAGS, 32'hFFFF_FFFF);

    // R9 write-one-to-clear, R11 irq
    wr(8'h04, 32'h0009_0000);
    wr(8'h08, 32'h0009_0000);
    tick(4);
    pins[2:1] = 2'b11;
    tick(6);
    rd(FLAGS, d); check("R9 two flags", d, 32'h6);
    check("R11 irq high", {31'b0, irq_req}, 32'h1);
    wr(FLAGS, 32'h0);
    rd(FLAGS, d); check("R9 zero write keeps", d, 32'h6);
    wr(FLAGS, 32'h2);
    rd(FLAGS, d); check("R9 selective clear", d, 32'h4);
    wr(FLAGS, 32'hFFFF_FFFF);
    rd(FLAGS, d); check("R9 clear all", d, 32'h0);
    tick(1);
    check("R11 irq low", {31'b0, irq_req}, 32'h0);

    // R2 masking by writing zero
    wr(8'h04, 32'h0);
    pins[1] = 1'b0; tick(6);
    pins[1] = 1'b1; tick(6);
    rd(FLAGS, d); check("R2 masked pin", d, 32'h0);

    // R4 level persists through clear
    wr(8'h0C, 32'h000C_0000);
    pins[3] = 1'b1; tick(6);
    wr(FLAGS, 32'h8);
    rd(FLAGS, d); check("R4 level refires", d, 32'h8);
    pins[3] = 1'b0; tick(6);
    wr(FLAGS, 32'h8);
    rd(FLAGS, d); check("R4 level gone", d, 32'h0);

    // R11 latency: flag at E3, irq at E4
    wr(8'h14, 32'h0009_0000);
    tick(4);
    pins[5] = 1'b1;
    tick(3);
    check("R11 irq before E4", {31'b0, irq_req}, 32'h0);
    tick(1);
    check("R11 irq at E4", {31'b0, irq_req}, 32'h1);
    wr(8'h14, 32'h0);
    wr(FLAGS, 32'hFFFF_FFFF);

    // R10 event coincides with clear
    wr(8'h18, 32'h0009_0000);
    tick(4);
    pins[6] = 1'b1;
    tick(2);
    bus_en = 1'b1; bus_we = 1'b1; bus_addr = FLAGS; bus_wdata = 32'hFFFF_FFFF;
    tick(1);
    bus_en = 1'b0; bus_we = 1'b0;
    rd(FLAGS, d); check("R10 set wins", d, 32'h40);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule